// File: doc/BRIEF.md
# Compare Match Output Waveform Unit

This block owns the single-bit output register behind one compare output pin of a 16-bit timer and decides, cycle by cycle, whether that bit is set, cleared, toggled or left alone. It does not count. A neighbouring counter supplies the events: a compare match strobe, TOP and BOTTOM strobes, the count direction and two flags about the compare value. The first flag says this channel's compare register is the one that defines TOP. The second says the compare value is equal to TOP. A software force strobe and a preset path are also provided, so that firmware can place the output at a known level before it connects it.

The result reaches the pin through a mux. When the 2-bit compare-output field is zero, the pin carries ordinary port data. When the field is nonzero, the pin carries the waveform bit instead. The data-direction bit controls the pin's output enable in both cases. All interfaces are plain level or strobe control signals. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `cmpwave_unit`

## Requirements
- R1: While reset is asserted (rst_n low, synchronous), wave_q is cleared to 0. After release, pin_val equals port_data as long as cmp_mode is 00.
- R2: With cmp_mode = 00, no match, force, TOP or BOTTOM event changes wave_q.
- R3: With wave_class = 00 (non-PWM), a match_evt acts on wave_q at the next clock edge according to cmp_mode. Mode 01 toggles the bit, 10 drives it to 0 and 11 drives it to 1.
- R4: In class 00, force_evt applies the same action as a match at the next edge. In classes 01 (single-slope) and 10 (dual-slope), force_evt has no effect.
- R5: In class 01, mode 10 clears wave_q on a match and sets it on bottom_evt, and mode 11 does the reverse. If a match and bottom_evt arrive in the same cycle, the match action wins. top_evt alone has no effect.
- R6: In class 01, when cmp_at_top = 1 and cmp_mode[1] = 1, the match is ignored. The BOTTOM-level action (set for mode 10, clear for mode 11) is applied on top_evt instead.
- R7: In class 10, mode 10 clears wave_q on a match while count_up = 1 and sets it on a match while count_up = 0. Mode 11 does the opposite. top_evt and bottom_evt have no effect.
- R8: In classes 01 and 10, mode 01 toggles wave_q on a match only when CHAN_A = 1 and cmp_defines_top = 1. Otherwise it takes no action.
- R9: pin_val equals wave_q whenever cmp_mode is nonzero, and equals port_data when cmp_mode is 00. pin_oe always equals dir_out.
- R10: Writing a new cmp_mode does not change wave_q on its own. The new mode acts first at the next match, force or PWM edge event.
- R11: preset_wr loads preset_val into wave_q at the next edge only while cmp_mode = 00. While cmp_mode is nonzero, preset_wr is ignored.
- R12: wave_class = 11 is reserved. No event changes wave_q in that class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_mode | input | 2 | Compare-output mode: 00 off, 01 toggle, 10 non-inverting/clear, 11 inverting/set |
| wave_class | input | 2 | 00 non-PWM, 01 single-slope PWM, 10 dual-slope PWM, 11 reserved |
| count_up | input | 1 | Counter direction, 1 = incrementing |
| match_evt | input | 1 | Compare match strobe |
| top_evt | input | 1 | Counter at TOP strobe |
| bottom_evt | input | 1 | Counter wraps/arrives at BOTTOM strobe |
| force_evt | input | 1 | Software force-compare strobe |
| cmp_defines_top | input | 1 | This channel's compare register sets TOP |
| cmp_at_top | input | 1 | Compare value equals TOP |
| dir_out | input | 1 | Pin data direction, 1 = output |
| port_data | input | 1 | Ordinary port output data |
| preset_wr | input | 1 | Direct write strobe for the output register |
| preset_val | input | 1 | Value for the direct write |
| wave_q | output | 1 | Output compare register |
| pin_val | output | 1 | Value presented to the pin driver |
| pin_oe | output | 1 | Pin output enable |

## Verification
The following are checked on every cycle: register stability under the off mode and under pure mode writes, the non-PWM set and toggle actions, dual-slope clearing on up-count matches, the no-effect cases of force in PWM classes and of the ignored match at TOP, the preset load, and the pin mux and enable. The bench's scenarios are the only evidence for the interplay of events arriving together. These are match against BOTTOM priority, the TOP-time substitute action, and the inverting forms. They also cover channel-A toggle gating and the reserved class, each started from a preset level so both directions of every edge are seen.

// File: rtl/cmpwave_pkg.sv
package cmpwave_pkg;
  localparam int MODE_W  = 2;
  localparam int CLASS_W = 2;

  typedef enum logic [CLASS_W-1:0] {
    CLS_NONPWM = 2'b00,
    CLS_SINGLE = 2'b01,
    CLS_DUAL   = 2'b10,
    CLS_RSVD   = 2'b11
  } wave_class_e;

  typedef enum logic [MODE_W-1:0] {
    CM_OFF    = 2'b00,
    CM_TOGGLE = 2'b01,
    CM_NONINV = 2'b10,
    CM_INV    = 2'b11
  } cmp_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } wave_act_e;

  function automatic logic apply_act(input wave_act_e act, input logic cur);
    case (act)
      ACT_CLR: apply_act = 1'b0;
      ACT_SET: apply_act = 1'b1;
      ACT_TGL: apply_act = ~cur;
      default: apply_act = cur;
    endcase
  endfunction
endpackage

// File: rtl/cmpwave_match_decode.sv
module cmpwave_match_decode
  import cmpwave_pkg::*;
#(
  parameter bit CHAN_A = 1'b1
) (
  input  cmp_mode_e   mode,
  input  wave_class_e cls,
  input  logic        count_up,
  input  logic        match_evt,
  input  logic        force_evt,
  input  logic        cmp_defines_top,
  input  logic        cmp_at_top,
  output wave_act_e   match_act
);
  logic tgl_ok;

  generate
    if (CHAN_A) begin : g_tgl_a
      assign tgl_ok = cmp_defines_top;
    end else begin : g_tgl_b
      assign tgl_ok = 1'b0;
    end
  endgenerate

  wave_act_e tgl_pwm;
  assign tgl_pwm = tgl_ok ? ACT_TGL : ACT_NONE;

  always_comb begin
    match_act = ACT_NONE;
    case (cls)
      CLS_NONPWM: begin
        if (match_evt || force_evt) begin
          case (mode)
            CM_TOGGLE: match_act = ACT_TGL;
            CM_NONINV: match_act = ACT_CLR;
            CM_INV:    match_act = ACT_SET;
            default:   match_act = ACT_NONE;
          endcase
        end
      end
      CLS_SINGLE: begin
        if (match_evt) begin
          case (mode)
            CM_TOGGLE: match_act = tgl_pwm;
            CM_NONINV: match_act = cmp_at_top ? ACT_NONE : ACT_CLR;
            CM_INV:    match_act = cmp_at_top ? ACT_NONE : ACT_SET;
            default:   match_act = ACT_NONE;
          endcase
        end
      end
      CLS_DUAL: begin
        if (match_evt) begin
          case (mode)
            CM_TOGGLE: match_act = tgl_pwm;
            CM_NONINV: match_act = count_up ? ACT_CLR : ACT_SET;
            CM_INV:    match_act = count_up ? ACT_SET : ACT_CLR;
            default:   match_act = ACT_NONE;
          endcase
        end
      end
      default: match_act = ACT_NONE;
    endcase
  end
endmodule

// File: rtl/cmpwave_edge_decode.sv
module cmpwave_edge_decode
  import cmpwave_pkg::*;
(
  input  cmp_mode_e   mode,
  input  wave_class_e cls,
  input  logic        top_evt,
  input  logic        bottom_evt,
  input  logic        cmp_at_top,
  output wave_act_e   edge_act
);
  logic period_edge;
  assign period_edge = bottom_evt || (top_evt && cmp_at_top);

  always_comb begin
    edge_act = ACT_NONE;
    if (cls == CLS_SINGLE && period_edge) begin
      case (mode)
        CM_NONINV: edge_act = ACT_SET;
        CM_INV:    edge_act = ACT_CLR;
        default:   edge_act = ACT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cmpwave_out_reg.sv
module cmpwave_out_reg
  import cmpwave_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cmp_mode_e mode,
  input  wave_act_e match_act,
  input  wave_act_e edge_act,
  input  logic      preset_wr,
  input  logic      preset_val,
  output logic      q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (mode == CM_OFF) begin
      if (preset_wr) q <= preset_val;
    end else if (match_act != ACT_NONE) begin
      q <= apply_act(match_act, q);
    end else if (edge_act != ACT_NONE) begin
      q <= apply_act(edge_act, q);
    end
  end
endmodule

// File: rtl/cmpwave_pin_mux.sv
module cmpwave_pin_mux
  import cmpwave_pkg::*;
(
  input  cmp_mode_e mode,
  input  logic      wave_bit,
  input  logic      port_data,
  input  logic      dir_out,
  output logic      pin_val,
  output logic      pin_oe
);
  assign pin_val = (mode != CM_OFF) ? wave_bit : port_data;
  assign pin_oe  = dir_out;
endmodule

// File: rtl/cmpwave_unit.sv
module cmpwave_unit
  import cmpwave_pkg::*;
#(
  parameter bit CHAN_A = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MODE_W-1:0]   cmp_mode,
  input  logic [CLASS_W-1:0]  wave_class,
  input  logic                count_up,
  input  logic                match_evt,
  input  logic                top_evt,
  input  logic                bottom_evt,
  input  logic                force_evt,
  input  logic                cmp_defines_top,
  input  logic                cmp_at_top,
  input  logic                dir_out,
  input  logic                port_data,
  input  logic                preset_wr,
  input  logic                preset_val,
  output logic                wave_q,
  output logic                pin_val,
  output logic                pin_oe
);
  cmp_mode_e   mode;
  wave_class_e cls;
  wave_act_e   match_act;
  wave_act_e   edge_act;

  assign mode = cmp_mode_e'(cmp_mode);
  assign cls  = wave_class_e'(wave_class);

  cmpwave_match_decode #(.CHAN_A(CHAN_A)) u_match (
    .mode(mode), .cls(cls), .count_up(count_up), .match_evt(match_evt),
    .force_evt(force_evt), .cmp_defines_top(cmp_defines_top),
    .cmp_at_top(cmp_at_top), .match_act(match_act)
  );

  cmpwave_edge_decode u_edge (
    .mode(mode), .cls(cls), .top_evt(top_evt), .bottom_evt(bottom_evt),
    .cmp_at_top(cmp_at_top), .edge_act(edge_act)
  );

  cmpwave_out_reg u_reg (
    .clk(clk), .rst_n(rst_n), .mode(mode), .match_act(match_act),
    .edge_act(edge_act), .preset_wr(preset_wr), .preset_val(preset_val),
    .q(wave_q)
  );

  cmpwave_pin_mux u_pin (
    .mode(mode), .wave_bit(wave_q), .port_data(port_data), .dir_out(dir_out),
    .pin_val(pin_val), .pin_oe(pin_oe)
  );
endmodule

// File: rtl/cmpwave_unit_chk.sv
module cmpwave_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cmp_mode,
  input logic [1:0] wave_class,
  input logic       count_up,
  input logic       match_evt,
  input logic       top_evt,
  input logic       bottom_evt,
  input logic       force_evt,
  input logic       cmp_at_top,
  input logic       dir_out,
  input logic       port_data,
  input logic       preset_wr,
  input logic       preset_val,
  input logic       wave_q,
  input logic       pin_val,
  input logic       pin_oe
);
  logic any_evt;
  assign any_evt = match_evt || force_evt || top_evt || bottom_evt;

  a_r2_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode == 2'b00 && !preset_wr) |=> $stable(wave_q));

  a_r3_nonpwm_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_class == 2'b00 && cmp_mode == 2'b11 && (match_evt || force_evt)) |=> wave_q);

  a_r3_nonpwm_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_class == 2'b00 && cmp_mode == 2'b01 && (match_evt || force_evt))
    |=> (wave_q != $past(wave_q)));

  a_r4_force_pwm_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_class != 2'b00 && force_evt && !match_evt && !top_evt && !bottom_evt
     && !(preset_wr && cmp_mode == 2'b00)) |=> $stable(wave_q));

  a_r6_match_at_top_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_class == 2'b01 && cmp_mode[1] && cmp_at_top && match_evt && !top_evt && !bottom_evt)
    |=> $stable(wave_q));

  a_r7_dual_up_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_class == 2'b10 && cmp_mode == 2'b10 && match_evt && count_up) |=> !wave_q);

  a_r10_mode_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode != 2'b00 && !any_evt) |=> $stable(wave_q));

  a_r11_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode == 2'b00 && preset_wr) |=> (wave_q == $past(preset_val)));

  always_comb begin
    if (rst_n) begin
      a_r9_pin_source: assert (pin_val == ((cmp_mode != 2'b00) ? wave_q : port_data));
      a_r9_pin_enable: assert (pin_oe == dir_out);
    end
  end
endmodule

bind cmpwave_unit cmpwave_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_mode(cmp_mode), .wave_class(wave_class),
  .count_up(count_up), .match_evt(match_evt), .top_evt(top_evt),
  .bottom_evt(bottom_evt), .force_evt(force_evt), .cmp_at_top(cmp_at_top),
  .dir_out(dir_out), .port_data(port_data), .preset_wr(preset_wr),
  .preset_val(preset_val), .wave_q(wave_q), .pin_val(pin_val), .pin_oe(pin_oe)
);

// File: tb/cmpwave_unit_bench.sv
module cmpwave_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cmp_mode, wave_class;
  logic       count_up, match_evt, top_evt, bottom_evt, force_evt;
  logic       cmp_defines_top, cmp_at_top, dir_out, port_data;
  logic       preset_wr, preset_val;
  logic       wave_q, pin_val, pin_oe;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk; // 125 MHz

  cmpwave_unit u_cmpwave_unit (
    .clk(clk), .rst_n(rst_n), .cmp_mode(cmp_mode), .wave_class(wave_class),
    .count_up(count_up), .match_evt(match_evt), .top_evt(top_evt),
    .bottom_evt(bottom_evt), .force_evt(force_evt),
    .cmp_defines_top(cmp_defines_top), .cmp_at_top(cmp_at_top),
    .dir_out(dir_out), .port_data(port_data), .preset_wr(preset_wr),
    .preset_val(preset_val), .wave_q(wave_q), .pin_val(pin_val), .pin_oe(pin_oe)
  );

  // Fields: com[16:15] cls[14:13] up[12] match[11] top[10] bot[9] force[8]
  //         deftop[7] attop[6] init[5] expect[4] req[3:0]
  localparam int NV = 29;
  localparam logic [16:0] VEC [NV] = '{
    17'b01_00_1_1_0_0_0_0_0_0_1_0011, // R3 toggle 0->1
    17'b01_00_1_1_0_0_0_0_0_1_0_0011, // R3 toggle 1->0
    17'b10_00_1_1_0_0_0_0_0_1_0_0011, // R3 clear
    17'b11_00_1_1_0_0_0_0_0_0_1_0011, // R3 set
    17'b10_00_1_0_0_0_0_0_0_1_1_0011, // R3 no match, hold
    17'b11_00_1_0_0_0_1_0_0_0_1_0100, // R4 force set
    17'b10_00_1_0_0_0_1_0_0_1_0_0100, // R4 force clear
    17'b10_01_1_0_0_0_1_0_0_1_1_0100, // R4 force ignored single-slope
    17'b11_10_1_0_0_0_1_0_0_0_0_0100, // R4 force ignored dual-slope
    17'b00_00_1_1_0_0_1_0_0_1_1_0010, // R2 off, match+force
    17'b00_01_1_1_1_1_0_0_0_0_0_0010, // R2 off, pwm events
    17'b10_01_1_1_0_0_0_0_0_1_0_0101, // R5 noninv clear on match
    17'b10_01_1_0_0_1_0_0_0_0_1_0101, // R5 noninv set at bottom
    17'b11_01_1_1_0_0_0_0_0_0_1_0101, // R5 inv set on match
    17'b11_01_1_0_0_1_0_0_0_1_0_0101, // R5 inv clear at bottom
    17'b10_01_1_1_0_1_0_0_0_0_0_0101, // R5 match beats bottom
    17'b10_01_1_0_1_0_0_0_0_0_0_0101, // R5 top alone no effect
    17'b10_01_1_1_0_0_0_0_1_1_1_0110, // R6 match at TOP ignored
    17'b10_01_1_0_1_0_0_0_1_0_1_0110, // R6 set done at TOP
    17'b11_01_1_0_1_0_0_0_1_1_0_0110, // R6 clear done at TOP
    17'b10_10_1_1_0_0_0_0_0_1_0_0111, // R7 noninv up clear
    17'b10_10_0_1_0_0_0_0_0_0_1_0111, // R7 noninv down set
    17'b11_10_1_1_0_0_0_0_0_0_1_0111, // R7 inv up set
    17'b11_10_0_1_0_0_0_0_0_1_0_0111, // R7 inv down clear
    17'b10_10_1_0_1_1_0_0_0_0_0_0111, // R7 top/bottom no effect
    17'b01_01_1_1_0_0_0_1_0_0_1_1000, // R8 toggle when A defines TOP
    17'b01_01_1_1_0_0_0_0_0_0_0_1000, // R8 no toggle otherwise
    17'b01_10_1_1_0_0_0_1_0_1_0_1000, // R8 dual toggle
    17'b11_11_1_1_0_1_1_0_0_0_0_1100  // R12 reserved class
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic quiet();
    count_up = 1'b1; match_evt = 1'b0; top_evt = 1'b0; bottom_evt = 1'b0;
    force_evt = 1'b0; cmp_defines_top = 1'b0; cmp_at_top = 1'b0;
    preset_wr = 1'b0; preset_val = 1'b0;
  endtask

  task automatic preset(input logic v);
    cmp_mode = 2'b00; preset_wr = 1'b1; preset_val = v;
    @(negedge clk);
    preset_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmp_mode = 2'b00; wave_class = 2'b00;
    dir_out = 1'b0; port_data = 1'b1;
    quiet();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset wave_q", wave_q, 1'b0);
    chk("R1 pin shows port data", pin_val, 1'b1);
    chk("R9 oe follows dir", pin_oe, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      quiet();
      preset(v[5]);
      wave_class = v[14:13]; cmp_mode = v[16:15]; count_up = v[12];
      match_evt = v[11]; top_evt = v[10]; bottom_evt = v[9]; force_evt = v[8];
      cmp_defines_top = v[7]; cmp_at_top = v[6];
      @(negedge clk);
      chk($sformatf("R%0d vector %0d", v[3:0], i), wave_q, v[4]);
      quiet();
    end

    // R9: pin mux and output enable
    quiet(); wave_class = 2'b00; preset(1'b0);
    port_data = 1'b1; dir_out = 1'b0; #1;
    chk("R9 off shows port", pin_val, 1'b1);
    cmp_mode = 2'b10; #1;
    chk("R9 connected shows wave", pin_val, 1'b0);
    dir_out = 1'b1; #1;
    chk("R9 oe high", pin_oe, 1'b1);

    // R10: mode writes alone leave the register untouched
    quiet(); wave_class = 2'b00; preset(1'b1);
    cmp_mode = 2'b10;
    repeat (3) @(negedge clk);
    chk("R10 mode write no effect", wave_q, 1'b1);
    cmp_mode = 2'b01;
    @(negedge clk);
    chk("R10 second mode write no effect", wave_q, 1'b1);
    match_evt = 1'b1;
    @(negedge clk);
    match_evt = 1'b0;
    chk("R10 first match applies new mode", wave_q, 1'b0);

    // R11: preset ignored while connected
    cmp_mode = 2'b11; preset_wr = 1'b1; preset_val = 1'b1;
    @(negedge clk);
    preset_wr = 1'b0;
    chk("R11 preset ignored when connected", wave_q, 1'b0);
    chk("R11 pin keeps wave level", pin_val, 1'b0);
    preset(1'b1);
    chk("R11 preset loads when off", wave_q, 1'b1);

    // R5: fast PWM cycle with narrow spike at compare 0
    quiet(); wave_class = 2'b01; preset(1'b0);
    cmp_mode = 2'b10; bottom_evt = 1'b1;
    @(negedge clk);
    bottom_evt = 1'b0; match_evt = 1'b1;
    chk("R5 spike high after bottom", wave_q, 1'b1);
    @(negedge clk);
    match_evt = 1'b0;
    chk("R5 spike cleared by match", wave_q, 1'b0);

    // R1: reset mid-run clears register
    preset(1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset clears register", wave_q, 1'b0);

    finish_run();
  end
endmodule